// File: doc/BRIEF.md
# Two-Level Round-Robin Thread Fetch Selector

This block decides, every clock cycle, which hardware thread of a fine-grained multithreaded pipeline may fetch. `NUM_THREADS` contexts are spread statically over `NUM_SLOTS` time slots. Thread k is bound to slot k mod `NUM_SLOTS`. A slot counter steps through the slots in a fixed cycle. In the current slot, the block grants one of that slot's ready threads in rotating order. When none of them is ready, the slot produces a bubble. The winner's thread number, slot number and program counter leave the block on registered outputs.

Each thread keeps its own program counter. One update port per cycle moves a thread's PC forward by one instruction or redirects it to a branch target. A redirect also raises a one-cycle kill indication for that thread, so that downstream stages drop the single instruction the thread fetched after the branch. Miss reports take a thread out of contention. Per-thread wake bits return it.

Top module: `thread_fetch_sel`

## Requirements
- R1: `fetch_slot_o` shows the slot that was current one cycle earlier. The slot advances by one each cycle and wraps from `NUM_SLOTS-1` to 0. The first cycle after reset is slot 0.
- R2: A thread is granted only in its own slot. Whenever `fetch_valid_o` is 1, `fetch_tid_o` mod `NUM_SLOTS` equals `fetch_slot_o`.
- R3: Member j of slot s is thread s + j*`NUM_SLOTS`. Each slot keeps a rotation pointer, which is 0 after reset. The slot grants the first ready member at or after the pointer, wrapping, and the pointer then moves to the member after the granted one.
- R4: A slot visit that grants nobody leaves that slot's pointer unchanged.
- R5: When no member of the current slot is ready, the output is a bubble. `fetch_valid_o`, `fetch_tid_o` and `fetch_pc_o` are all 0, and `fetch_slot_o` still names the slot.
- R6: A miss (`miss_valid_i` with `miss_tid_i`) clears that thread's ready flag, and a 1 in `wake_i[t]` sets it. The change applies to selections from the next cycle on. If a miss and a wake name the same thread in the same cycle, the miss wins.
- R7: After reset every PC holds `RESET_PC`. `fetch_pc_o` is the granted thread's PC as held before the selecting edge. An update with `upd_redirect_i`=0 adds `PC_STEP`; an update with `upd_redirect_i`=1 loads `upd_target_i`.
- R8: A redirect in cycle n makes `kill_valid_o` 1 with `kill_tid_o` equal to the redirected thread in cycle n+1. `kill_valid_o` is 0 after every cycle with no redirect.
- R9: While reset is held, every output is 0 and all threads are marked ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wake_i | input | NUM_THREADS | Per-thread set of the ready flag |
| miss_valid_i | input | 1 | Miss report valid |
| miss_tid_i | input | TID_W | Thread that missed |
| upd_valid_i | input | 1 | PC update valid |
| upd_redirect_i | input | 1 | 1: load target, 0: sequential advance |
| upd_tid_i | input | TID_W | Thread whose PC is updated |
| upd_target_i | input | PC_W | Branch target |
| fetch_valid_o | output | 1 | A thread was granted |
| fetch_tid_o | output | TID_W | Granted thread |
| fetch_slot_o | output | SLOT_W | Slot of this fetch cycle |
| fetch_pc_o | output | PC_W | PC of granted thread |
| kill_valid_o | output | 1 | Drop the last instruction fetched by `kill_tid_o` |
| kill_tid_o | output | TID_W | Thread to nullify |

## Verification
The properties assume that `miss_tid_i` and `upd_tid_i` always name an existing thread, and that inputs change only between clock edges. The bubble and slot-ownership checks rely on nothing else, because they depend only on the block's own registers. The stimulus uses thread numbers below eight only and drives every input at the falling edge. It applies at most one miss and one PC update per cycle, as the single-entry ports require.

// File: rtl/thread_fetch_pkg.sv
package thread_fetch_pkg;

   // Width of an index over n items, never below one bit.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Modular increment used by the rotation pointers.
   function automatic int wrap_next(input int v, input int n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/tfs_slot_ctr.sv
module tfs_slot_ctr #(
   parameter int NUM_SLOTS = 4,
   parameter int SLOT_W    = 2
) (
   input  logic              clk,
   input  logic              rst,
   output logic [SLOT_W-1:0] slot_o
);
   generate
      if (NUM_SLOTS > 1) begin : g_cycle
         logic [SLOT_W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (rst)
               slot_q <= '0;
            else if (slot_q == SLOT_W'(NUM_SLOTS - 1))
               slot_q <= '0;
            else
               slot_q <= slot_q + 1'b1;
         end
         assign slot_o = slot_q;
      end else begin : g_single
         assign slot_o = '0;
      end
   endgenerate
endmodule

// File: rtl/tfs_ready_tbl.sv
module tfs_ready_tbl #(
   parameter int NUM_THREADS = 8,
   parameter int TID_W       = 3
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NUM_THREADS-1:0] wake_i,
   input  logic                   miss_valid_i,
   input  logic [TID_W-1:0]       miss_tid_i,
   output logic [NUM_THREADS-1:0] ready_o
);
   logic [NUM_THREADS-1:0] ready_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ready_q <= '1;
      end else begin
         for (int t = 0; t < NUM_THREADS; t++) begin
            if (miss_valid_i && (miss_tid_i == TID_W'(t)))
               ready_q[t] <= 1'b0;
            else if (wake_i[t])
               ready_q[t] <= 1'b1;
         end
      end
   end

   assign ready_o = ready_q;
endmodule

// File: rtl/tfs_pc_file.sv
module tfs_pc_file #(
   parameter int              NUM_THREADS = 8,
   parameter int              TID_W       = 3,
   parameter int              PC_W        = 32,
   parameter logic [PC_W-1:0] RESET_PC    = '0,
   parameter int              PC_STEP     = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [TID_W-1:0] rd_tid_i,
   output logic [PC_W-1:0]  rd_pc_o,
   input  logic             upd_valid_i,
   input  logic             upd_redirect_i,
   input  logic [TID_W-1:0] upd_tid_i,
   input  logic [PC_W-1:0]  upd_target_i,
   output logic             kill_valid_o,
   output logic [TID_W-1:0] kill_tid_o
);
   logic [PC_W-1:0]  pc_q [NUM_THREADS];
   logic             kill_q;
   logic [TID_W-1:0] kill_tid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int t = 0; t < NUM_THREADS; t++)
            pc_q[t] <= RESET_PC;
      end else if (upd_valid_i) begin
         if (upd_redirect_i)
            pc_q[upd_tid_i] <= upd_target_i;
         else
            pc_q[upd_tid_i] <= pc_q[upd_tid_i] + PC_W'(PC_STEP);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         kill_q     <= 1'b0;
         kill_tid_q <= '0;
      end else begin
         kill_q     <= upd_valid_i && upd_redirect_i;
         kill_tid_q <= (upd_valid_i && upd_redirect_i) ? upd_tid_i : '0;
      end
   end

   assign rd_pc_o      = pc_q[rd_tid_i];
   assign kill_valid_o = kill_q;
   assign kill_tid_o   = kill_tid_q;
endmodule

// File: rtl/tfs_slot_arb.sv
module tfs_slot_arb #(
   parameter int NUM_THREADS = 8,
   parameter int NUM_SLOTS   = 4,
   parameter int TID_W       = 3,
   parameter int SLOT_W      = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [SLOT_W-1:0]      slot_i,
   input  logic [NUM_THREADS-1:0] ready_i,
   output logic                   grant_o,
   output logic [TID_W-1:0]       grant_tid_o
);
   import thread_fetch_pkg::*;

   localparam int PER_SLOT = NUM_THREADS / NUM_SLOTS;
   localparam int PTR_W    = idx_width(PER_SLOT);

   generate
      if (PER_SLOT > 1) begin : g_rotate
         logic [PTR_W-1:0] ptr_q [NUM_SLOTS];
         logic [PTR_W-1:0] pick;
         logic             hit;

         // Scan the slot's members starting at the rotation pointer.
         always_comb begin
            int m;
            hit  = 1'b0;
            pick = '0;
            for (int k = 0; k < PER_SLOT; k++) begin
               m = int'(ptr_q[slot_i]) + k;
               if (m >= PER_SLOT)
                  m = m - PER_SLOT;
               if (!hit && ready_i[int'(slot_i) + m * NUM_SLOTS]) begin
                  hit  = 1'b1;
                  pick = PTR_W'(m);
               end
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int s = 0; s < NUM_SLOTS; s++)
                  ptr_q[s] <= '0;
            end else if (hit) begin
               ptr_q[slot_i] <= PTR_W'(wrap_next(int'(pick), PER_SLOT));
            end
         end

         assign grant_o     = hit;
         assign grant_tid_o = TID_W'(int'(slot_i) + int'(pick) * NUM_SLOTS);
      end else begin : g_direct
         // One thread per slot: no rotation state is needed.
         assign grant_o     = ready_i[slot_i];
         assign grant_tid_o = TID_W'(slot_i);
      end
   endgenerate
endmodule

// File: rtl/thread_fetch_sel.sv
module thread_fetch_sel #(
   parameter int              NUM_THREADS = 8,
   parameter int              NUM_SLOTS   = 4,
   parameter int              PC_W        = 32,
   parameter logic [PC_W-1:0] RESET_PC    = '0,
   parameter int              PC_STEP     = 4,
   localparam int             TID_W       = thread_fetch_pkg::idx_width(NUM_THREADS),
   localparam int             SLOT_W      = thread_fetch_pkg::idx_width(NUM_SLOTS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NUM_THREADS-1:0] wake_i,
   input  logic                   miss_valid_i,
   input  logic [TID_W-1:0]       miss_tid_i,
   input  logic                   upd_valid_i,
   input  logic                   upd_redirect_i,
   input  logic [TID_W-1:0]       upd_tid_i,
   input  logic [PC_W-1:0]        upd_target_i,
   output logic                   fetch_valid_o,
   output logic [TID_W-1:0]       fetch_tid_o,
   output logic [SLOT_W-1:0]      fetch_slot_o,
   output logic [PC_W-1:0]        fetch_pc_o,
   output logic                   kill_valid_o,
   output logic [TID_W-1:0]       kill_tid_o
);
   generate
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("NUM_SLOTS must be at least 1");
      end
      if (NUM_THREADS < 2) begin : g_bad_threads
         $error("NUM_THREADS must be at least 2");
      end
      if ((NUM_THREADS % NUM_SLOTS) != 0) begin : g_bad_ratio
         $error("NUM_THREADS must be a multiple of NUM_SLOTS");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("PC_W too narrow");
      end
   endgenerate

   logic [SLOT_W-1:0]      slot;
   logic [NUM_THREADS-1:0] ready;
   logic                   grant;
   logic [TID_W-1:0]       grant_tid;
   logic [PC_W-1:0]        grant_pc;

   tfs_slot_ctr #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) i_slot_ctr (
      .clk    (clk),
      .rst    (rst),
      .slot_o (slot)
   );

   tfs_ready_tbl #(
      .NUM_THREADS (NUM_THREADS),
      .TID_W       (TID_W)
   ) i_ready_tbl (
      .clk          (clk),
      .rst          (rst),
      .wake_i       (wake_i),
      .miss_valid_i (miss_valid_i),
      .miss_tid_i   (miss_tid_i),
      .ready_o      (ready)
   );

   tfs_slot_arb #(
      .NUM_THREADS (NUM_THREADS),
      .NUM_SLOTS   (NUM_SLOTS),
      .TID_W       (TID_W),
      .SLOT_W      (SLOT_W)
   ) i_slot_arb (
      .clk         (clk),
      .rst         (rst),
      .slot_i      (slot),
      .ready_i     (ready),
      .grant_o     (grant),
      .grant_tid_o (grant_tid)
   );

   tfs_pc_file #(
      .NUM_THREADS (NUM_THREADS),
      .TID_W       (TID_W),
      .PC_W        (PC_W),
      .RESET_PC    (RESET_PC),
      .PC_STEP     (PC_STEP)
   ) i_pc_file (
      .clk            (clk),
      .rst            (rst),
      .rd_tid_i       (grant_tid),
      .rd_pc_o        (grant_pc),
      .upd_valid_i    (upd_valid_i),
      .upd_redirect_i (upd_redirect_i),
      .upd_tid_i      (upd_tid_i),
      .upd_target_i   (upd_target_i),
      .kill_valid_o   (kill_valid_o),
      .kill_tid_o     (kill_tid_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         fetch_valid_o <= 1'b0;
         fetch_tid_o   <= '0;
         fetch_slot_o  <= '0;
         fetch_pc_o    <= '0;
      end else begin
         fetch_valid_o <= grant;
         fetch_slot_o  <= slot;
         fetch_tid_o   <= grant ? grant_tid : '0;
         fetch_pc_o    <= grant ? grant_pc : '0;
      end
   end
endmodule

// File: rtl/tfs_chk.sv
module tfs_chk #(
   parameter int NUM_THREADS = 8,
   parameter int NUM_SLOTS   = 4,
   parameter int PC_W        = 32,
   localparam int TID_W      = thread_fetch_pkg::idx_width(NUM_THREADS),
   localparam int SLOT_W     = thread_fetch_pkg::idx_width(NUM_SLOTS)
) (
   input logic              clk,
   input logic              rst,
   input logic              miss_valid_i,
   input logic [TID_W-1:0]  miss_tid_i,
   input logic              upd_valid_i,
   input logic              upd_redirect_i,
   input logic [TID_W-1:0]  upd_tid_i,
   input logic              fetch_valid_o,
   input logic [TID_W-1:0]  fetch_tid_o,
   input logic [SLOT_W-1:0] fetch_slot_o,
   input logic [PC_W-1:0]   fetch_pc_o,
   input logic              kill_valid_o,
   input logic [TID_W-1:0]  kill_tid_o
);
   // Counts edges since reset so that slot history is only compared
   // once two post-reset outputs exist.
   logic [1:0] warm_q;
   always_ff @(posedge clk) begin
      if (rst)
         warm_q <= 2'd0;
      else if (warm_q != 2'd2)
         warm_q <= warm_q + 2'd1;
   end

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd2) |-> (fetch_slot_o == (($past(fetch_slot_o) == SLOT_W'(NUM_SLOTS - 1)) ?
                                             SLOT_W'(0) : SLOT_W'($past(fetch_slot_o) + 1'b1)))); // R1

   AST_TID_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
      fetch_valid_o |-> ((int'(fetch_tid_o) % NUM_SLOTS) == int'(fetch_slot_o))); // R2

   AST_BUBBLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
      !fetch_valid_o |-> (fetch_tid_o == '0 && fetch_pc_o == '0)); // R5

   AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      miss_valid_i |=> ##1 !(fetch_valid_o && fetch_tid_o == $past(miss_tid_i, 2))); // R6

   AST_KILL_AFTER_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      (upd_valid_i && upd_redirect_i) |=> (kill_valid_o && kill_tid_o == $past(upd_tid_i))); // R8

   AST_KILL_ONLY_ON_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      !(upd_valid_i && upd_redirect_i) |=> !kill_valid_o); // R8
endmodule

bind thread_fetch_sel tfs_chk #(
   .NUM_THREADS (NUM_THREADS),
   .NUM_SLOTS   (NUM_SLOTS),
   .PC_W        (PC_W)
) i_chk (.*);

// File: tb/test_thread_fetch_sel.sv
module test_thread_fetch_sel;
   localparam int          T      = 8;
   localparam int          C      = 4;
   localparam logic [31:0] RST_PC = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  wake_i;
   logic        miss_valid_i;
   logic [2:0]  miss_tid_i;
   logic        upd_valid_i;
   logic        upd_redirect_i;
   logic [2:0]  upd_tid_i;
   logic [31:0] upd_target_i;
   logic        fetch_valid_o;
   logic [2:0]  fetch_tid_o;
   logic [1:0]  fetch_slot_o;
   logic [31:0] fetch_pc_o;
   logic        kill_valid_o;
   logic [2:0]  kill_tid_o;

   always #2 clk = ~clk;

   thread_fetch_sel #(
      .NUM_THREADS (T),
      .NUM_SLOTS   (C),
      .PC_W        (32),
      .RESET_PC    (RST_PC),
      .PC_STEP     (4)
   ) i_thread_fetch_sel (
      .clk            (clk),
      .rst            (rst),
      .wake_i         (wake_i),
      .miss_valid_i   (miss_valid_i),
      .miss_tid_i     (miss_tid_i),
      .upd_valid_i    (upd_valid_i),
      .upd_redirect_i (upd_redirect_i),
      .upd_tid_i      (upd_tid_i),
      .upd_target_i   (upd_target_i),
      .fetch_valid_o  (fetch_valid_o),
      .fetch_tid_o    (fetch_tid_o),
      .fetch_slot_o   (fetch_slot_o),
      .fetch_pc_o     (fetch_pc_o),
      .kill_valid_o   (kill_valid_o),
      .kill_tid_o     (kill_tid_o)
   );

   // {miss_v, miss_tid[2:0], wake[7:0], exp_valid, exp_slot[1:0], exp_tid[2:0]}
   localparam int NVEC = 16;
   localparam logic [17:0] VEC [NVEC] = '{
      {1'b1, 3'd5, 8'h00, 1'b1, 2'd0, 3'd0},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 3'd1},
      {1'b1, 3'd1, 8'h00, 1'b1, 2'd2, 3'd2},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 3'd3},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd4},
      {1'b0, 3'd0, 8'h22, 1'b0, 2'd1, 3'd0},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 3'd6},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 3'd7},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd0},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 3'd5},
      {1'b1, 3'd3, 8'h08, 1'b1, 2'd2, 3'd2},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 3'd7},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd4},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 3'd1},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 3'd6},
      {1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 3'd7}
   };

   int          n_chk = 0;
   int          n_bad = 0;
   logic [17:0] v;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_in();
      wake_i         = '0;
      miss_valid_i   = 1'b0;
      miss_tid_i     = '0;
      upd_valid_i    = 1'b0;
      upd_redirect_i = 1'b0;
      upd_tid_i      = '0;
      upd_target_i   = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      clear_in();
   endtask

   // R3 rotation, R4 kept pointer, R5 bubble, R6 miss over wake
   function automatic string tag_of(input int i);
      if (i == 5) return "R5";
      if (i == 9) return "R4";
      if (i == 11 || i == 15) return "R6";
      return "R3";
   endfunction

   task automatic chk_fetch(input string req, input logic vld,
                            input int tid, input logic [31:0] pc);
      chk(req, "valid", 32'(fetch_valid_o), 32'(vld));
      chk(req, "tid",   32'(fetch_tid_o),   32'(tid));
      chk("R7", "pc",   fetch_pc_o,         pc);
   endtask

   task automatic chk_reset_state();
      chk("R9", "valid", 32'(fetch_valid_o), 32'd0);
      chk("R9", "slot",  32'(fetch_slot_o),  32'd0);
      chk("R9", "tid",   32'(fetch_tid_o),   32'd0);
      chk("R9", "pc",    fetch_pc_o,         32'd0);
      chk("R9", "kill",  32'(kill_valid_o),  32'd0);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: all requirements actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1;
      clear_in();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_reset_state();
      rst = 1'b0;

      // Vector walk: rotation, bubbles, misses and wakes.
      for (int i = 0; i < NVEC; i++) begin
         v            = VEC[i];
         miss_valid_i = v[17];
         miss_tid_i   = v[16:14];
         wake_i       = v[13:6];
         tick();
         chk(tag_of(i), "valid", 32'(fetch_valid_o), 32'(v[5]));
         chk("R1", "slot", 32'(fetch_slot_o), 32'(v[4:3]));
         chk(tag_of(i), "tid", 32'(fetch_tid_o), 32'(v[2:0]));
         chk(v[5] ? "R7" : "R5", "pc", fetch_pc_o, v[5] ? RST_PC : 32'd0);
         if (fetch_valid_o)
            chk("R2", "tid mod slots", 32'(int'(fetch_tid_o) % C), 32'(fetch_slot_o));
      end

      // Reset again, then PC update and kill tests.
      rst = 1'b1;
      tick();
      tick();
      chk_reset_state();
      rst = 1'b0;

      upd_valid_i = 1'b1;
      upd_tid_i   = 3'd0;
      tick();
      chk_fetch("R3", 1'b1, 0, RST_PC);            // old PC seen on same-edge update
      chk("R8", "kill after advance", 32'(kill_valid_o), 32'd0);

      upd_valid_i    = 1'b1;
      upd_redirect_i = 1'b1;
      upd_tid_i      = 3'd4;
      upd_target_i   = 32'h0000_1000;
      tick();
      chk_fetch("R3", 1'b1, 1, RST_PC);
      chk("R8", "kill valid", 32'(kill_valid_o), 32'd1);
      chk("R8", "kill tid",   32'(kill_tid_o),   32'd4);

      tick();
      chk("R8", "kill drops", 32'(kill_valid_o), 32'd0);
      chk_fetch("R3", 1'b1, 2, RST_PC);
      tick();
      chk_fetch("R3", 1'b1, 3, RST_PC);
      tick();
      chk_fetch("R3", 1'b1, 4, 32'h0000_1000);     // R7 redirect target
      tick();
      tick();
      tick();
      tick();
      chk_fetch("R3", 1'b1, 0, RST_PC + 32'd4);    // R7 sequential advance

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule